// File: doc/BRIEF.md
# Power-Management Event Router (SMI / SCI)

The router gathers single-cycle event pulses from power-management sources, records each one in a sticky status bit, and sends pending events to one of two places. One is an active-low system-management interrupt line (`smi_n`). The other is a level interrupt (SCI) placed on one selectable line of an interrupt vector. Software reaches the block through a small register file. There it sets per-source enables, chooses the delivery mode and the SCI line, arms the block again after an SMI, clears status bits by writing ones, and can trap a sleep-entry request.

Each source maps to one status bit, and several sources may share a bit. Status bits 0–3 and the sleep-trap bit (6) only ever raise an SMI. Bits 4 and 5 are SCI-capable: when the mode bit is 1 they raise an SCI, and when it is 0 they raise an SMI. Only one SMI can be outstanding at a time. The line stays low until software writes the end-of-SMI bit.

Top module: `pm_evt_router`

## Requirements
- R1: After synchronous reset, `smi_n` is 1, `sci_irq` is all zero, and the status, enable and control registers all read 0.
- R2: A pulse on `evt_pulse[i]` while enable bit i (register 1, bit i) is 1 sets status bit map(i), where map = src0→0, src1→1, src2/src3/src4→2, src5→3, src6→4, src7→5. A pulse while the enable is 0 leaves the status unchanged.
- R3: Status (register 0) is sticky. Writing a 1 to a bit clears it. If the same bit is set by an event in the same cycle, the set wins.
- R4: A read of register 0 (status), 1 (enables) or 2 (control: bit0 SCI mode, bit1 global SMI enable, bit2 end-of-SMI reads 0, bit3 sleep trap, bit4 APIC mode, bits 10:8 line code) returns data on `rdata` one cycle after `rd_en`.
- R5: With the global SMI enable set and SMI armed, `smi_n` goes low one clock after an enabled SMI-routed status bit becomes set.
- R6: While the global SMI enable (control bit1) is 0, `smi_n` never goes low.
- R7: Once low, `smi_n` stays low until control bit2 is written as 1. It is high in the following cycle. If an enabled event is still pending, it goes low again one cycle later.
- R8: With SCI mode (control bit0) set, status bits 4 and 5 drive SCI and not SMI, while bits 0–3 and 6 still raise SMI. With the mode clear, bits 4 and 5 raise SMI and SCI stays idle.
- R9: `sci_irq` stays asserted while an enabled SCI-capable status bit is set in SCI mode, and drops one cycle after that bit is cleared.
- R10: Line code 0/1/2 selects line 9/10/11. Codes 4–7 select lines 20–23, but only when APIC mode (control bit4) is 1. Code 3, or codes 4–7 without APIC mode, drive no line. At most one line is ever active.
- R11: Writing 1 to bit0 of register 3 sets status bit 6 (and so can raise SMI) only while the sleep-trap bit (control bit3) is 1. Otherwise the write has no effect.
- R12: A status bit takes part in delivery only while at least one of its mapped source enables is 1 (the sleep-trap bit for bit 6). A set status bit whose enables are all 0 raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| smi_n | output | 1 | Active-low system-management interrupt |
| sci_irq | output | NUM_IRQ | SCI driven onto the selected interrupt line |

## Verification
On every cycle, the assertions check several rules: the outstanding SMI holds until end-of-SMI and is released right after it, SMI fires only under the global enable and SCI only in SCI mode, at most one interrupt line is active and lines 20–23 only in APIC mode, and status bits stay sticky when no clear is requested. Other behaviour appears only in the bench's scenarios. These cover the source-to-status mapping with shared bits, the set-beats-clear collision, SMI re-firing after end-of-SMI while an event is still pending, the exact line chosen for each code, the sleep-write trap, and delivery stopping when a status bit's enables are withdrawn.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  // Register offsets
  localparam int REG_STS = 0;
  localparam int REG_EN  = 1;
  localparam int REG_CTL = 2;
  localparam int REG_SLP = 3;

  // Control register bit positions
  localparam int CTL_MODE = 0;
  localparam int CTL_GLB  = 1;
  localparam int CTL_EOS  = 2;
  localparam int CTL_TRAP = 3;
  localparam int CTL_APIC = 4;
  localparam int CTL_LINE = 8;

  typedef struct packed {
    logic [2:0] line_sel;
    logic       apic;
    logic       slp_trap;
    logic       smi_glb;
    logic       sci_mode;
  } pm_ctl_t;

  // Interrupt line addressed by a line code
  function automatic logic [4:0] line_target(input logic [2:0] code);
    case (code)
      3'd0:    line_target = 5'd9;
      3'd1:    line_target = 5'd10;
      3'd2:    line_target = 5'd11;
      3'd4:    line_target = 5'd20;
      3'd5:    line_target = 5'd21;
      3'd6:    line_target = 5'd22;
      3'd7:    line_target = 5'd23;
      default: line_target = 5'd0;
    endcase
  endfunction

  // Upper lines are reachable only in APIC mode; code 3 is unused
  function automatic logic line_legal(input logic [2:0] code, input logic apic);
    if (code < 3'd3)       line_legal = 1'b1;
    else if (code == 3'd3) line_legal = 1'b0;
    else                   line_legal = apic;
  endfunction

endpackage

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 8,
  parameter int NUM_STS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_STS-1:0]  sts,
  output logic [NUM_SRC-1:0]  en_q,
  output pm_ctl_t             ctl_q,
  output logic                eos_wr,
  output logic                slp_wr,
  output logic [NUM_STS-1:0]  sts_clr,
  output logic [DATA_W-1:0]   rdata
);

  logic hit_sts, hit_en, hit_ctl, hit_slp;
  logic [DATA_W-1:0] rd_mux;

  assign hit_sts = (addr == ADDR_W'(REG_STS));
  assign hit_en  = (addr == ADDR_W'(REG_EN));
  assign hit_ctl = (addr == ADDR_W'(REG_CTL));
  assign hit_slp = (addr == ADDR_W'(REG_SLP));

  assign eos_wr  = wr_en && hit_ctl && wdata[CTL_EOS];
  assign slp_wr  = wr_en && hit_slp && wdata[0];
  assign sts_clr = (wr_en && hit_sts) ? wdata[NUM_STS-1:0] : '0;

  wire unused_wdata = ^{wdata[7:5], wdata[DATA_W-1:11]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (hit_en) en_q <= wdata[NUM_SRC-1:0];
      if (hit_ctl) begin
        ctl_q.sci_mode <= wdata[CTL_MODE];
        ctl_q.smi_glb  <= wdata[CTL_GLB];
        ctl_q.slp_trap <= wdata[CTL_TRAP];
        ctl_q.apic     <= wdata[CTL_APIC];
        ctl_q.line_sel <= wdata[CTL_LINE +: 3];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sts) begin
      rd_mux[NUM_STS-1:0] = sts;
    end else if (hit_en) begin
      rd_mux[NUM_SRC-1:0] = en_q;
    end else if (hit_ctl) begin
      rd_mux[CTL_MODE]       = ctl_q.sci_mode;
      rd_mux[CTL_GLB]        = ctl_q.smi_glb;
      rd_mux[CTL_TRAP]       = ctl_q.slp_trap;
      rd_mux[CTL_APIC]       = ctl_q.apic;
      rd_mux[CTL_LINE +: 3]  = ctl_q.line_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status #(
  parameter int NUM_SRC = 8,
  parameter int NUM_STS = 7,
  parameter int IDX_W   = 3,
  parameter logic [NUM_SRC*IDX_W-1:0] SRC_MAP = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  evt_pulse,
  input  logic [NUM_SRC-1:0]  en_q,
  input  logic                slp_wr,
  input  logic                slp_trap,
  input  logic [NUM_STS-1:0]  sts_clr,
  output logic [NUM_STS-1:0]  sts,
  output logic [NUM_STS-1:0]  sts_en
);

  localparam int SLP_BIT = NUM_STS - 1;

  logic [NUM_STS-1:0] sts_set;

  // One slice per source-fed status bit: OR of every mapped source
  for (genvar j = 0; j < SLP_BIT; j++) begin : g_bit
    always_comb begin
      sts_set[j] = 1'b0;
      sts_en[j]  = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (SRC_MAP[i*IDX_W +: IDX_W] == IDX_W'(j)) begin
          sts_en[j]  = sts_en[j] | en_q[i];
          sts_set[j] = sts_set[j] | (evt_pulse[i] & en_q[i]);
        end
      end
    end
  end

  // Sleep-write trap occupies the top status bit
  assign sts_set[SLP_BIT] = slp_wr & slp_trap;
  assign sts_en[SLP_BIT]  = slp_trap;

  always_ff @(posedge clk) begin
    if (rst) sts <= '0;
    else     sts <= (sts & ~sts_clr) | sts_set;
  end

endmodule

// File: rtl/pm_evt_smi.sv
module pm_evt_smi #(
  parameter int NUM_STS = 7,
  parameter logic [NUM_STS-1:0] SCI_CAP = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_STS-1:0] sts,
  input  logic [NUM_STS-1:0] sts_en,
  input  logic               sci_mode,
  input  logic               smi_glb,
  input  logic               eos_wr,
  output logic               smi_n
);

  logic [NUM_STS-1:0] smi_route;
  logic               pend;

  assign smi_route = sci_mode ? ~SCI_CAP : {NUM_STS{1'b1}};
  assign pend      = smi_glb && (|(sts & sts_en & smi_route));

  // smi_n high means armed; low means one SMI outstanding
  always_ff @(posedge clk) begin
    if (rst) begin
      smi_n <= 1'b1;
    end else if (!smi_n) begin
      if (eos_wr) smi_n <= 1'b1;
    end else if (pend) begin
      smi_n <= 1'b0;
    end
  end

endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci
  import pm_evt_pkg::*;
#(
  parameter int NUM_STS = 7,
  parameter int NUM_IRQ = 24,
  parameter logic [NUM_STS-1:0] SCI_CAP = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_STS-1:0] sts,
  input  logic [NUM_STS-1:0] sts_en,
  input  logic               sci_mode,
  input  logic               apic,
  input  logic [2:0]         line_sel,
  output logic [NUM_IRQ-1:0] sci_irq
);

  logic               lvl;
  logic               legal;
  logic [4:0]         tgt;
  logic [NUM_IRQ-1:0] hit;

  assign lvl   = sci_mode && (|(sts & sts_en & SCI_CAP));
  assign legal = line_legal(line_sel, apic);
  assign tgt   = line_target(line_sel);

  for (genvar l = 0; l < NUM_IRQ; l++) begin : g_line
    assign hit[l] = legal && (tgt == 5'(l));
  end

  always_ff @(posedge clk) begin
    if (rst) sci_irq <= '0;
    else     sci_irq <= hit & {NUM_IRQ{lvl}};
  end

endmodule

// File: rtl/pm_evt_router.sv
module pm_evt_router
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 8,
  parameter int NUM_STS = 7,
  parameter int NUM_IRQ = 24,
  parameter logic [NUM_SRC*3-1:0] SRC_MAP =
    {3'd5, 3'd4, 3'd3, 3'd2, 3'd2, 3'd2, 3'd1, 3'd0},
  parameter logic [NUM_STS-1:0] SCI_CAP = 7'b0110000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               smi_n,
  output logic [NUM_IRQ-1:0] sci_irq
);

  localparam int IDX_W = 3;

  logic [NUM_SRC-1:0] en_q;
  pm_ctl_t            ctl_q;
  logic               eos_wr;
  logic               slp_wr;
  logic [NUM_STS-1:0] sts_clr;
  logic [NUM_STS-1:0] sts;
  logic [NUM_STS-1:0] sts_en;

  pm_evt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .NUM_STS(NUM_STS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .sts(sts), .en_q(en_q), .ctl_q(ctl_q), .eos_wr(eos_wr),
    .slp_wr(slp_wr), .sts_clr(sts_clr), .rdata(rdata)
  );

  pm_evt_status #(
    .NUM_SRC(NUM_SRC), .NUM_STS(NUM_STS), .IDX_W(IDX_W), .SRC_MAP(SRC_MAP)
  ) u_status (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .en_q(en_q),
    .slp_wr(slp_wr), .slp_trap(ctl_q.slp_trap), .sts_clr(sts_clr),
    .sts(sts), .sts_en(sts_en)
  );

  pm_evt_smi #(
    .NUM_STS(NUM_STS), .SCI_CAP(SCI_CAP)
  ) u_smi (
    .clk(clk), .rst(rst), .sts(sts), .sts_en(sts_en),
    .sci_mode(ctl_q.sci_mode), .smi_glb(ctl_q.smi_glb), .eos_wr(eos_wr),
    .smi_n(smi_n)
  );

  pm_evt_sci #(
    .NUM_STS(NUM_STS), .NUM_IRQ(NUM_IRQ), .SCI_CAP(SCI_CAP)
  ) u_sci (
    .clk(clk), .rst(rst), .sts(sts), .sts_en(sts_en),
    .sci_mode(ctl_q.sci_mode), .apic(ctl_q.apic), .line_sel(ctl_q.line_sel),
    .sci_irq(sci_irq)
  );

endmodule

// File: rtl/pm_evt_router_chk.sv
module pm_evt_router_chk #(
  parameter int NUM_STS = 7,
  parameter int NUM_IRQ = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               smi_n,
  input logic [NUM_IRQ-1:0] sci_irq,
  input logic               sci_mode,
  input logic               smi_glb,
  input logic               apic,
  input logic               eos_wr,
  input logic [NUM_STS-1:0] sts,
  input logic [NUM_STS-1:0] sts_clr
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (smi_n && (sci_irq == '0)));

  assert_smi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!smi_n && !eos_wr) |=> !smi_n);

  assert_smi_release_R7: assert property (@(posedge clk) disable iff (rst)
    (!smi_n && eos_wr) |=> smi_n);

  assert_smi_needs_glb_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(smi_n) |-> $past(smi_glb));

  assert_sci_needs_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (|sci_irq) |-> $past(sci_mode));

  assert_one_line_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sci_irq));

  assert_apic_lines_R10: assert property (@(posedge clk) disable iff (rst)
    (|sci_irq[NUM_IRQ-1:20]) |-> $past(apic));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (sts_clr == '0) |=> ((sts & $past(sts)) == $past(sts)));

endmodule

bind pm_evt_router pm_evt_router_chk #(
  .NUM_STS(NUM_STS), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk(clk), .rst(rst), .smi_n(smi_n), .sci_irq(sci_irq),
  .sci_mode(ctl_q.sci_mode), .smi_glb(ctl_q.smi_glb), .apic(ctl_q.apic),
  .eos_wr(eos_wr), .sts(sts), .sts_clr(sts_clr)
);

// File: tb/pm_evt_router_tb.sv
module pm_evt_router_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_pulse = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        smi_n;
  logic [23:0] sci_irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pm_evt_router u_dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .smi_n(smi_n), .sci_irq(sci_irq)
  );

  // ---------------- reference model ----------------
  int map_of [8] = '{0, 1, 2, 2, 2, 3, 4, 5};
  logic [6:0]  m_sts;
  logic [7:0]  m_en;
  logic        m_mode, m_glb, m_trap, m_apic;
  logic [2:0]  m_line;
  logic        m_smi_n;
  logic [23:0] m_irq;
  logic [15:0] m_rdata;
  logic [6:0]  t_sen, t_set, t_clr, t_act;
  logic        t_pend, t_sci, t_eos;
  int          t_line;

  function automatic int line_for(input logic [2:0] c, input logic ap);
    if (c == 3'd0) return 9;
    if (c == 3'd1) return 10;
    if (c == 3'd2) return 11;
    if (c == 3'd3) return -1;
    return ap ? 16 + int'(c) : -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sts = '0; m_en = '0; m_mode = 0; m_glb = 0; m_trap = 0; m_apic = 0;
      m_line = '0; m_smi_n = 1; m_irq = '0; m_rdata = '0;
    end else begin
      t_sen = '0; t_set = '0;
      for (int i = 0; i < 8; i++) begin
        if (m_en[i]) t_sen[map_of[i]] = 1'b1;
        if (m_en[i] && evt_pulse[i]) t_set[map_of[i]] = 1'b1;
      end
      t_sen[6] = m_trap;
      if (wr_en && addr == 3 && wdata[0] && m_trap) t_set[6] = 1'b1;
      t_clr = (wr_en && addr == 0) ? wdata[6:0] : '0;
      t_act = m_sts & t_sen;
      t_pend = m_glb && (m_mode ? |(t_act & 7'b1001111) : |t_act);
      t_sci  = m_mode && |(t_act & 7'b0110000);
      t_eos  = wr_en && addr == 2 && wdata[2];
      if (!m_smi_n) begin
        if (t_eos) m_smi_n = 1'b1;
      end else if (t_pend) m_smi_n = 1'b0;
      t_line = line_for(m_line, m_apic);
      m_irq = (t_sci && t_line >= 0) ? (24'd1 << t_line) : 24'd0;
      if (rd_en) begin
        case (addr)
          3'd0: m_rdata = {9'd0, m_sts};
          3'd1: m_rdata = {8'd0, m_en};
          3'd2: m_rdata = {5'd0, m_line, 3'd0, m_apic, m_trap, 1'b0, m_glb, m_mode};
          default: m_rdata = '0;
        endcase
      end
      m_sts = (m_sts & ~t_clr) | t_set;
      if (wr_en && addr == 1) m_en = wdata[7:0];
      if (wr_en && addr == 2) begin
        m_mode = wdata[0]; m_glb = wdata[1]; m_trap = wdata[3];
        m_apic = wdata[4]; m_line = wdata[10:8];
      end
    end
  end

  // Per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (smi_n !== m_smi_n || sci_irq !== m_irq || rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s model: smi_n=%0b/%0b irq=%h/%h rdata=%h/%h (actual/expected)",
                 cur_req, smi_n, m_smi_n, sci_irq, m_irq, rdata, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, 32'(rdata), 32'(exp));
  endtask

  task automatic pulse(input int s);
    evt_pulse[s] = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R1";
    chk("R1 smi_n", 32'(smi_n), 32'd1);
    chk("R1 sci_irq", 32'(sci_irq), 32'd0);
    rd_chk("R1 status", 3'd0, 16'h0000);
    rd_chk("R1 control", 3'd2, 16'h0000);

    // R2: masked pulse is ignored, mapped pulses land on their bits
    cur_req = "R2";
    pulse(0);
    rd_chk("R2 masked pulse", 3'd0, 16'h0000);
    wr(3'd1, 16'h003D);               // enables src0,2,3,4,5
    rd_chk("R4 enable readback", 3'd1, 16'h003D);
    pulse(3);
    rd_chk("R2 shared bit from src3", 3'd0, 16'h0004);
    pulse(0); pulse(5);
    rd_chk("R2 src0 and src5", 3'd0, 16'h000D);

    // R3: write-one-to-clear and set-beats-clear
    cur_req = "R3";
    wr(3'd0, 16'h0008);
    rd_chk("R3 clear bit3", 3'd0, 16'h0005);
    evt_pulse[0] = 1'b1;
    wr(3'd0, 16'h0001);
    evt_pulse = '0;
    rd_chk("R3 set wins over clear", 3'd0, 16'h0005);

    // R6: global enable off -> no SMI despite pending status
    cur_req = "R6";
    idle(3);
    chk("R6 smi held off", 32'(smi_n), 32'd1);

    // R5/R7: enable globally; pending bits fire
    cur_req = "R5";
    wr(3'd2, 16'h0002);
    chk("R5 no SMI in write-commit cycle", 32'(smi_n), 32'd1);
    @(negedge clk);
    chk("R5 SMI one cycle later", 32'(smi_n), 32'd0);
    rd_chk("R4 control readback", 3'd2, 16'h0002);
    cur_req = "R7";
    pulse(2);
    idle(4);
    chk("R7 SMI held until EOS", 32'(smi_n), 32'd0);
    wr(3'd0, 16'h007F);
    wr(3'd2, 16'h0006);               // EOS with nothing pending
    chk("R7 released after EOS", 32'(smi_n), 32'd1);
    idle(2);
    chk("R7 stays armed", 32'(smi_n), 32'd1);
    pulse(5);
    @(negedge clk);
    chk("R7 re-fires for new event", 32'(smi_n), 32'd0);
    wr(3'd2, 16'h0006);               // EOS while bit3 still pending
    chk("R7 high for one cycle", 32'(smi_n), 32'd1);
    @(negedge clk);
    chk("R7 re-fires when pending", 32'(smi_n), 32'd0);

    // R8/R9/R10: SCI mode
    cur_req = "R8";
    wr(3'd0, 16'h007F);
    wr(3'd1, 16'h00C1);               // src0, src6, src7
    wr(3'd2, 16'h0007);               // mode + glb + EOS, line code 0
    pulse(6);
    @(negedge clk);
    chk("R8 SCI-capable not on SMI", 32'(smi_n), 32'd1);
    chk("R10 code0 -> line 9", 32'(sci_irq), 32'h000200);
    cur_req = "R10";
    wr(3'd2, 16'h0203);
    @(negedge clk);
    chk("R10 code2 -> line 11", 32'(sci_irq), 32'h000800);
    wr(3'd2, 16'h0503);
    @(negedge clk);
    chk("R10 code5 w/o APIC -> none", 32'(sci_irq), 32'h000000);
    wr(3'd2, 16'h0513);
    @(negedge clk);
    chk("R10 code5 APIC -> line 21", 32'(sci_irq), 32'h200000);
    wr(3'd2, 16'h0313);
    @(negedge clk);
    chk("R10 code3 -> none", 32'(sci_irq), 32'h000000);
    wr(3'd2, 16'h0703);
    @(negedge clk);
    chk("R10 code7 w/o APIC -> none", 32'(sci_irq), 32'h000000);
    wr(3'd2, 16'h0113);
    idle(3);
    chk("R9 level held", 32'(sci_irq), 32'h000400);
    cur_req = "R9";
    wr(3'd0, 16'h0010);
    @(negedge clk);
    chk("R9 drops after clear", 32'(sci_irq), 32'h000000);
    cur_req = "R8";
    pulse(0);
    @(negedge clk);
    chk("R8 SMI-only bit still SMI", 32'(smi_n), 32'd0);
    chk("R8 no SCI for SMI-only bit", 32'(sci_irq), 32'h000000);
    wr(3'd0, 16'h007F);
    wr(3'd2, 16'h0006);               // SMI mode, EOS
    pulse(7);
    @(negedge clk);
    chk("R8 bit5 on SMI when mode clear", 32'(smi_n), 32'd0);
    chk("R8 no SCI when mode clear", 32'(sci_irq), 32'h000000);

    // R11: sleep-write trap
    cur_req = "R11";
    wr(3'd0, 16'h007F);
    wr(3'd2, 16'h0006);
    wr(3'd3, 16'h0001);
    idle(2);
    rd_chk("R11 untrapped write ignored", 3'd0, 16'h0000);
    chk("R11 no SMI untrapped", 32'(smi_n), 32'd1);
    wr(3'd2, 16'h000A);               // glb + trap
    wr(3'd3, 16'h0001);
    @(negedge clk);
    chk("R11 trapped write -> SMI", 32'(smi_n), 32'd0);
    rd_chk("R11 sleep status", 3'd0, 16'h0040);

    // R12: status without any live enable raises nothing
    cur_req = "R12";
    wr(3'd0, 16'h007F);
    wr(3'd1, 16'h0010);               // src4 only
    pulse(4);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0006);               // EOS, trap off
    idle(3);
    chk("R12 masked status silent", 32'(smi_n), 32'd1);
    rd_chk("R12 status retained", 3'd0, 16'h0004);
    wr(3'd1, 16'h0008);               // src3 shares bit2
    @(negedge clk);
    chk("R12 shared enable revives", 32'(smi_n), 32'd0);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule